// File: doc/BRIEF.md
# I2S Serial Audio Transmitter

This block drives a single serial audio data line in I2S format from two 24-bit parallel samples, one per stereo channel. It does not make its own bit or word clocks. The external codec supplies the bit clock and the word-select clock. The block samples both of them inside its own system clock domain and acts on the edges it detects.

Each channel has a one-word holding register. The register is written whenever that channel's ready strobe is high. When a falling bit-clock edge finds that word select has changed level, the block copies the selected holding register into an output shift register. The copy is padded to a 32-slot word. The block then sends the word most significant bit first, one slot per bit-clock period, beginning one bit-clock period after the word-select transition.

The serial line changes only on detected falling edges of the bit clock, so a receiver can sample it on the rising edges.

Top module: `i2s_tx`

## Requirements
- R1: After reset both holding registers read as zero, `sdout` is low, and the words sent before any strobe are all zeros.
- R2: A cycle with `left_valid` (or `right_valid`) high stores `left_data` (or `right_data`) in that channel's holding register. When several strobes arrive before a word starts, the last one is the one sent.
- R3: A word transfer starts only when a falling bit-clock edge finds `lrclk` at a level different from the level seen at the previous falling edge. If `lrclk` keeps its level, no new word is loaded and the line carries zeros once the current word is finished.
- R4: The most significant bit of the new word is driven at the first falling bit-clock edge after the edge that saw the word-select change, which is one bit-clock period after the transition.
- R5: Each word takes 32 bit-clock slots: the 24 sample bits, most significant first, then 8 zero slots.
- R6: `lrclk` low selects the left holding register and `lrclk` high selects the right one. The channel is chosen from the new `lrclk` level at the transition.
- R7: A strobe that arrives while a word is being sent updates the holding register but leaves the bits of that word unchanged. The new value goes out in the next word for that channel.
- R8: `sdout` changes only in the system-clock cycle that follows a detected falling edge of `sclk`, and it stays stable for the rest of the bit-clock period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial bit clock from the codec, sampled in the `clk` domain |
| lrclk | input | 1 | Word select from the codec: low selects left, high selects right |
| left_data | input | 24 | Left-channel sample, two's complement |
| left_valid | input | 1 | Strobe that writes `left_data` into the left holding register |
| right_data | input | 24 | Right-channel sample, two's complement |
| right_valid | input | 1 | Strobe that writes `right_data` into the right holding register |
| sdout | output | 1 | Serial I2S data, updated after falling `sclk` edges |

## Verification
The assertions check four things on every cycle. Each holding register follows its strobe and otherwise stays unchanged. `sdout` never moves without a detected falling bit-clock edge. Once a word has been loaded, slots 24 and later are zero. `sdout` is low after reset.

Some behaviour depends on whole sequences, and only the bench's scenarios can show it:
- the one-period delay before the most significant bit;
- the choice of channel from the `lrclk` level;
- the word kept intact when a strobe arrives in the middle of a word;
- the absence of a reload while `lrclk` holds its level.

The bench checks these bit by bit against a model of the serial stream built from the requirements.

// File: rtl/i2s_tx_pkg.sv
// Shared definitions for the I2S transmitter.
// Assumes two stereo channels and indexes them with the enum below.
package i2s_tx_pkg;

    localparam int NUM_CH = 2;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

endpackage

// File: rtl/i2s_tx_sync.sv
// Brings sclk and lrclk into the clk domain through equal-length
// synchronizer chains, and reports falling sclk edges and word-select
// changes seen at those edges.
// Assumes clk is at least 4x faster than sclk and that lrclk changes
// together with falling sclk.
module i2s_tx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic lrclk,
    output logic fall_evt,
    output logic lr_edge,
    output logic lr_now
);

    logic [STAGES-1:0] sclk_pipe;
    logic [STAGES-1:0] lr_pipe;
    logic              sclk_last;
    logic              lr_at_fall;

    generate
        if (STAGES == 1) begin : g_one
            // Single-flop capture of both clocks
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sclk_pipe <= '0;
                    lr_pipe   <= '0;
                end else begin
                    sclk_pipe <= sclk;
                    lr_pipe   <= lrclk;
                end
            end
        end else begin : g_multi
            // Multi-flop shift chain for both clocks
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sclk_pipe <= '0;
                    lr_pipe   <= '0;
                end else begin
                    sclk_pipe <= {sclk_pipe[STAGES-2:0], sclk};
                    lr_pipe   <= {lr_pipe[STAGES-2:0], lrclk};
                end
            end
        end
    endgenerate

    // Remember the previous synchronized sclk level and the lrclk level at the last fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_last  <= 1'b0;
            lr_at_fall <= 1'b0;
        end else begin
            sclk_last <= sclk_pipe[STAGES-1];
            if (fall_evt) begin
                lr_at_fall <= lr_pipe[STAGES-1];
            end
        end
    end

    // Decode edge events from the synchronized levels
    always_comb begin
        lr_now   = lr_pipe[STAGES-1];
        fall_evt = sclk_last & ~sclk_pipe[STAGES-1];
        lr_edge  = fall_evt & (lr_now != lr_at_fall);
    end

endmodule

// File: rtl/i2s_tx_hold.sv
// One-word holding register for a single channel.
// Loads din whenever load is high and otherwise keeps its value.
module i2s_tx_hold #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);

    // Capture the sample on its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end

endmodule

// File: rtl/i2s_tx_shift.sv
// Output serializer. On load it takes a sample word padded with zeros
// to SLOTS bits. On every shift event it drives the current top bit
// and moves the register up by one place. Shift and load happen on the
// same event, so the last slot of the old word is driven while the new
// word is captured.
// Assumes SLOTS >= WIDTH.
module i2s_tx_shift #(
    parameter int WIDTH = 24,
    parameter int SLOTS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             load,
    input  logic [WIDTH-1:0] word,
    output logic             sdout
);

    localparam int PAD = SLOTS - WIDTH;

    logic [SLOTS-1:0] shreg;
    logic [SLOTS-1:0] framed;

    generate
        if (PAD == 0) begin : g_nopad
            assign framed = word;
        end else begin : g_pad
            assign framed = {word, {PAD{1'b0}}};
        end
    endgenerate

    // Advance the serial word and drive one bit per shift event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            sdout <= 1'b0;
        end else if (shift_en) begin
            sdout <= shreg[SLOTS-1];
            if (load) begin
                shreg <= framed;
            end else begin
                shreg <= {shreg[SLOTS-2:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/i2s_tx.sv
// I2S transmitter top. Two per-channel holding registers feed a
// serializer that is loaded whenever word select changes at a falling
// bit-clock edge. lrclk low selects left and high selects right.
// Assumes sclk and lrclk come from an external codec and are much
// slower than clk.
module i2s_tx
    import i2s_tx_pkg::*;
#(
    parameter int SAMPLE_W    = 24,
    parameter int SLOT_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk,
    input  logic                lrclk,
    input  logic [SAMPLE_W-1:0] left_data,
    input  logic                left_valid,
    input  logic [SAMPLE_W-1:0] right_data,
    input  logic                right_valid,
    output logic                sdout
);

    logic                fall_evt;
    logic                lr_edge;
    logic                lr_now;
    logic [SAMPLE_W-1:0] ch_data  [NUM_CH];
    logic [NUM_CH-1:0]   ch_valid;
    logic [SAMPLE_W-1:0] hold_q   [NUM_CH];
    logic [SAMPLE_W-1:0] sel_word;

    // Gather the channel inputs into indexed form
    always_comb begin
        ch_data[CH_LEFT]   = left_data;
        ch_data[CH_RIGHT]  = right_data;
        ch_valid[CH_LEFT]  = left_valid;
        ch_valid[CH_RIGHT] = right_valid;
    end

    i2s_tx_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (sclk),
        .lrclk    (lrclk),
        .fall_evt (fall_evt),
        .lr_edge  (lr_edge),
        .lr_now   (lr_now)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            i2s_tx_hold #(
                .WIDTH (SAMPLE_W)
            ) u_hold (
                .clk   (clk),
                .rst_n (rst_n),
                .load  (ch_valid[c]),
                .din   (ch_data[c]),
                .q     (hold_q[c])
            );
        end
    endgenerate

    // Pick the holding register named by the new word-select level
    always_comb begin
        sel_word = lr_now ? hold_q[CH_RIGHT] : hold_q[CH_LEFT];
    end

    i2s_tx_shift #(
        .WIDTH (SAMPLE_W),
        .SLOTS (SLOT_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (fall_evt),
        .load     (lr_edge),
        .word     (sel_word),
        .sdout    (sdout)
    );

endmodule

// File: rtl/i2s_tx_chk.sv
// Protocol checker for i2s_tx, bound into every instance of it.
// Counts slots since the last word load so that it can check the
// zero padding.
module i2s_tx_chk #(
    parameter int SAMPLE_W = 24,
    parameter int SLOT_W   = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                fall_evt,
    input logic                lr_edge,
    input logic                sdout,
    input logic                left_valid,
    input logic [SAMPLE_W-1:0] left_data,
    input logic                right_valid,
    input logic [SAMPLE_W-1:0] right_data,
    input logic [SAMPLE_W-1:0] hold_left,
    input logic [SAMPLE_W-1:0] hold_right
);

    localparam int CW = $clog2(SLOT_W) + 2;

    logic [CW-1:0] slot_cnt;
    logic          loaded;

    // Track the slot index of the word on the line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_cnt <= '0;
            loaded   <= 1'b0;
        end else if (lr_edge) begin
            slot_cnt <= '0;
            loaded   <= 1'b1;
        end else if (fall_evt && (slot_cnt != {CW{1'b1}})) begin
            slot_cnt <= slot_cnt + 1'b1;
        end
    end

    // R1
    reset_low_chk: assert property (@(posedge clk) !rst_n |=> !sdout);

    // R2
    left_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        left_valid |=> hold_left == $past(left_data));

    // R2
    right_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        right_valid |=> hold_right == $past(right_data));

    // R7
    left_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !left_valid |=> $stable(hold_left));

    // R7
    right_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !right_valid |=> $stable(hold_right));

    // R8
    sdout_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_evt |=> $stable(sdout));

    // R5
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_evt && loaded && (slot_cnt >= CW'(SAMPLE_W))) |=> !sdout);

endmodule

bind i2s_tx i2s_tx_chk #(
    .SAMPLE_W (SAMPLE_W),
    .SLOT_W   (SLOT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fall_evt    (fall_evt),
    .lr_edge     (lr_edge),
    .sdout       (sdout),
    .left_valid  (left_valid),
    .left_data   (left_data),
    .right_valid (right_valid),
    .right_data  (right_data),
    .hold_left   (hold_q[0]),
    .hold_right  (hold_q[1])
);

// File: tb/i2s_tx_test.sv
// Bench for i2s_tx. Generates sclk at clk/8 and lrclk on falling sclk.
// Models the expected serial stream from the requirements and checks
// every slot.
module i2s_tx_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1;
    logic        lrclk = 1'b0;
    logic [23:0] left_data = '0;
    logic        left_valid = 1'b0;
    logic [23:0] right_data = '0;
    logic        right_valid = 1'b0;
    logic        sdout;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state
    logic [31:0] m_sh   = '0;
    logic [23:0] m_hold [2];
    logic        m_lr   = 1'b0;
    logic        m_out  = 1'b0;

    always #10 clk = ~clk;

    i2s_tx uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk        (sclk),
        .lrclk       (lrclk),
        .left_data   (left_data),
        .left_valid  (left_valid),
        .right_data  (right_data),
        .right_valid (right_valid),
        .sdout       (sdout)
    );

    task automatic chk(input bit ok, input string tag, input logic act, input logic exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: sdout actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Next model bit at a falling sclk edge
    function automatic void model_fall(input logic lr);
        m_out = m_sh[31];
        if (lr != m_lr) begin
            m_sh = {m_hold[lr], 8'h00};
            m_lr = lr;
        end else begin
            m_sh = {m_sh[30:0], 1'b0};
        end
    endfunction

    // One sclk period, with an optional strobe in the high phase
    task automatic slot(input logic lr, input bit stb, input bit stb_ch,
                        input logic [23:0] stb_val, input string tag);
        logic early;
        @(negedge clk);
        sclk  = 1'b0;
        lrclk = lr;
        model_fall(lr);
        repeat (4) @(negedge clk);
        sclk  = 1'b1;
        early = sdout;
        if (stb) begin
            if (stb_ch) begin
                right_data  = stb_val;
                right_valid = 1'b1;
            end else begin
                left_data  = stb_val;
                left_valid = 1'b1;
            end
            @(negedge clk);
            left_valid  = 1'b0;
            right_valid = 1'b0;
            m_hold[stb_ch] = stb_val;
            repeat (2) @(negedge clk);
        end else begin
            repeat (3) @(negedge clk);
        end
        chk(sdout === m_out, tag, sdout, m_out);
        chk(sdout === early, "R8", sdout, early);
    endtask

    // A word-select period of 32 slots; stb_j < 0 means no strobe
    task automatic period(input logic lr, input int stb_j, input bit stb_ch,
                          input logic [23:0] stb_val, input string tag);
        bit changed;
        changed = (lr != m_lr);
        for (int j = 0; j < 32; j++) begin
            string t;
            if (!changed)      t = "R3";
            else if (j == 1)   t = "R4";
            else if (j == 0 || j > 24) t = "R5";
            else               t = tag;
            slot(lr, (j == stb_j), stb_ch, stb_val, t);
        end
    endtask

    // Main sequence
    initial begin
        m_hold[0] = '0;
        m_hold[1] = '0;
        void'($urandom(32'h5EED_1234));
        repeat (4) @(negedge clk);
        chk(sdout === 1'b0, "R1", sdout, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(sdout === 1'b0, "R1", sdout, 1'b0);

        // Words sent before any strobe are all zeros
        period(1'b0, -1, 1'b0, '0, "R1");
        period(1'b1, -1, 1'b0, '0, "R1");
        period(1'b0, -1, 1'b0, '0, "R1");

        // Load both channels and check the channel choice
        period(1'b1, 4, 1'b0, 24'hA5C3F1, "R6");
        period(1'b0, 9, 1'b1, 24'h3C0F96, "R6");
        period(1'b1, -1, 1'b0, '0, "R6");
        period(1'b0, -1, 1'b0, '0, "R6");

        // Corner values
        period(1'b1, 2, 1'b0, 24'hFFFFFF, "R6");
        period(1'b0, 2, 1'b1, 24'h800001, "R6");
        period(1'b1, -1, 1'b0, '0, "R5");
        period(1'b0, -1, 1'b0, '0, "R5");

        // Last strobe before a word wins
        period(1'b1, 3, 1'b0, 24'h111111, "R2");
        period(1'b0, 20, 1'b1, 24'h222222, "R2");
        period(1'b1, 28, 1'b0, 24'h5A5A5A, "R2");
        period(1'b0, -1, 1'b0, '0, "R2");

        // Strobe in the middle of a word leaves that word intact
        period(1'b1, 10, 1'b1, 24'h0F0F0F, "R7");
        period(1'b0, 12, 1'b0, 24'hC33C99, "R7");
        period(1'b1, -1, 1'b0, '0, "R7");
        period(1'b0, -1, 1'b0, '0, "R7");

        // Word select held: no reload, zeros follow
        period(1'b0, -1, 1'b0, '0, "R3");
        period(1'b1, -1, 1'b0, '0, "R6");
        period(1'b1, 6, 1'b1, 24'hFEDCBA, "R3");
        period(1'b0, -1, 1'b0, '0, "R6");

        // Constrained random traffic
        for (int k = 0; k < 24; k++) begin
            int sj;
            logic ch;
            logic [23:0] val;
            sj  = ($urandom % 4 == 0) ? -1 : int'($urandom % 32);
            ch  = 1'($urandom % 2);
            val = 24'($urandom);
            period(1'(k % 2 == 0), sj, ch, val, "R6");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule